// File: doc/BRIEF.md
# Trace Byte Sink with Stop Syndrome

The block takes a stream of trace bytes and writes each accepted byte to memory at a write pointer. The pointer steps up by one per byte and runs inside a window set by a base pointer and a limit pointer. When a byte goes to the last address below the limit, the pointer reloads the base. A mode input picks between two behaviours at that point. In fill mode the wrap ends collection. In circular mode the wrap is only noted and collection goes on.

Alongside the writer sits a 64-bit status word that software reads and writes through a simple port. The word holds the following:
- sticky flags for wrap, trigger and external abort;
- a stopped flag;
- an interrupt-pending flag;
- a 6-bit event class;
- a 6-bit cause code;
- a 24-bit second syndrome field.

Collection can be ended by any of these:
- a fill-mode wrap;
- a trigger pulse;
- a manual stop pulse;
- a write fault reported by the memory path;
- an external abort.

The first cause is captured, raises the interrupt, and holds until software clears the stopped flag.

Top module: `trace_sink_ctrl`

## Requirements
- R1: In the cycle after synchronous reset ends, every status bit reads 0, `irq` is 0, and the first byte accepted is written at `base_ptr`.
- R2: A byte presented while collection runs is written in the same cycle: `mem_we`=1, `mem_addr` is the write pointer, and `mem_wdata` is the byte. The pointer advances by one for the next byte.
- R3: A byte written at `limit_ptr`-1 makes the next pointer equal `base_ptr` and sets wrap bit 20. Bit 20 stays set until software writes it to 0.
- R4: In fill mode (`circ_mode`=0), such a wrap stops collection. After the cycle, stopped bit 17 is 1, cause code bits [5:0] are 0b000001, and event class bits [31:26] are 0b000000.
- R5: In circular mode (`circ_mode`=1), a wrap sets bit 20 only. Bit 17 stays 0 and bytes go on being written from `base_ptr`.
- R6: A trigger pulse sets sticky bit 21 and stops collection with code 0b000010. A manual-stop pulse stops collection with code 0b000011. Code 0b000000 means not stopped.
- R7: A write fault stops collection with event class 0b100100 when `flt_stage2`=0, or 0b100101 when `flt_stage2`=1. In either case `flt_code` is placed in bits [5:0].
- R8: An external abort sets sticky bit 18 and stops collection with event class 0 and code 0.
- R9: Every stop that gets recorded sets interrupt bit 22. The `irq` output equals bit 22.
- R10: While bit 17 is 1, no byte is written and the pointer holds. A later cause leaves the class and code unchanged. Bits 21 and 18 still become set.
- R11: A byte and a stop cause in the same cycle: the byte is written and the stop applies from the next cycle. Among simultaneous causes, the one recorded follows this priority, highest first: fault, external abort, manual stop, trigger, fill-mode wrap.
- R12: A software write replaces bits [55:32], [31:26], 22, 21, 20, 18, 17 and [5:0] with the written value, and takes precedence over any hardware event in the same cycle. Bits [63:56], [25:23], 19 and [16:6] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_vld | input | 1 | Trace byte offered |
| byte_data | input | 8 | Trace byte |
| base_ptr | input | ADDR_W | First address of the buffer window |
| limit_ptr | input | ADDR_W | One past the last address of the window |
| circ_mode | input | 1 | 1: circular, 0: fill (stop on wrap) |
| trig_pulse | input | 1 | Trigger event |
| mstop_pulse | input | 1 | Manual stop request |
| flt_vld | input | 1 | Write fault reported |
| flt_stage2 | input | 1 | Fault is second stage |
| flt_code | input | 6 | Fault status code |
| ext_abort | input | 1 | External abort on a trace write |
| sw_wr | input | 1 | Software write to the status word |
| sw_wdata | input | 64 | Software write data |
| sw_rdata | output | 64 | Status word |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write byte |
| irq | output | 1 | Interrupt request |

## Verification
The memory strobe, address and byte are combinational from the current pointer and stopped flag. The bench therefore samples them 1 time unit after driving inputs, in the same cycle.

Every status bit and `irq` changes on the clock edge that sees the cause. The bench compares them at the following falling edge against a reference model, which it steps once per edge. Same-cycle cases (a byte together with a stop cause, or a software write together with a trigger) are arranged so that the byte check and the status check fall in these two separate windows.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
   localparam int CODE_W = 6;
   localparam int MSS2_W = 24;

   localparam logic [CODE_W-1:0] EC_GENERAL = 6'b000000;
   localparam logic [CODE_W-1:0] EC_S1_FLT  = 6'b100100;
   localparam logic [CODE_W-1:0] EC_S2_FLT  = 6'b100101;

   localparam logic [CODE_W-1:0] CS_NONE    = 6'b000000;
   localparam logic [CODE_W-1:0] CS_FULL    = 6'b000001;
   localparam logic [CODE_W-1:0] CS_TRIG    = 6'b000010;
   localparam logic [CODE_W-1:0] CS_MANUAL  = 6'b000011;

   typedef struct packed {
      logic [MSS2_W-1:0] mss2;
      logic [CODE_W-1:0] ec;
      logic              irq;
      logic              trg;
      logic              wrap;
      logic              ea;
      logic              stopped;
      logic [CODE_W-1:0] code;
   } synd_t;

   function automatic logic [63:0] synd_pack(synd_t s);
      logic [63:0] w;
      w          = '0;
      w[55:32]   = s.mss2;
      w[31:26]   = s.ec;
      w[22]      = s.irq;
      w[21]      = s.trg;
      w[20]      = s.wrap;
      w[18]      = s.ea;
      w[17]      = s.stopped;
      w[5:0]     = s.code;
      return w;
   endfunction

   function automatic synd_t synd_unpack(logic [63:0] w);
      synd_t s;
      s.mss2    = w[55:32];
      s.ec      = w[31:26];
      s.irq     = w[22];
      s.trg     = w[21];
      s.wrap    = w[20];
      s.ea      = w[18];
      s.stopped = w[17];
      s.code    = w[5:0];
      return s;
   endfunction
endpackage

// File: rtl/tsb_ptr.sv
module tsb_ptr #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base_ptr,
   input  logic [ADDR_W-1:0] limit_ptr,
   input  logic              take,
   output logic [ADDR_W-1:0] wptr,
   output logic              at_end
);
   localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

   generate
      if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_width
         $error("tsb_ptr: ADDR_W must be within 2..64");
      end
   endgenerate

   assign at_end = (wptr == (limit_ptr - ONE));

   always_ff @(posedge clk) begin
      if (!rst_n)
         wptr <= base_ptr;
      else if (take)
         wptr <= at_end ? base_ptr : (wptr + ONE);
   end

   p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (take && at_end) |=> (wptr == $past(base_ptr)));
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !at_end) |=> (wptr == $past(wptr) + ONE));
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!take) |=> $stable(wptr));
endmodule

// File: rtl/tsb_cause.sv
module tsb_cause
   import tsb_pkg::*;
(
   input  logic              flt_vld,
   input  logic              flt_stage2,
   input  logic [CODE_W-1:0] flt_code,
   input  logic              ext_abort,
   input  logic              mstop,
   input  logic              trig,
   input  logic              fill_wrap,
   output logic              cause_vld,
   output logic [CODE_W-1:0] cause_ec,
   output logic [CODE_W-1:0] cause_code
);
   always_comb begin
      cause_vld  = 1'b1;
      cause_ec   = EC_GENERAL;
      cause_code = CS_NONE;
      if (flt_vld) begin
         cause_ec   = flt_stage2 ? EC_S2_FLT : EC_S1_FLT;
         cause_code = flt_code;
      end else if (ext_abort) begin
         cause_code = CS_NONE;
      end else if (mstop) begin
         cause_code = CS_MANUAL;
      end else if (trig) begin
         cause_code = CS_TRIG;
      end else if (fill_wrap) begin
         cause_code = CS_FULL;
      end else begin
         cause_vld  = 1'b0;
      end
   end

   always_comb begin
      if (flt_vld) a_fault_first_r11: assert (cause_vld && cause_code == flt_code);
   end
endmodule

// File: rtl/tsb_synd.sv
module tsb_synd
   import tsb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_wr,
   input  logic [63:0]       sw_wdata,
   input  logic              wrap_ev,
   input  logic              trig,
   input  logic              ext_abort,
   input  logic              cause_vld,
   input  logic [CODE_W-1:0] cause_ec,
   input  logic [CODE_W-1:0] cause_code,
   output synd_t             q
);
   synd_t sw_val;
   logic  unused_sw_bits;

   assign sw_val         = synd_unpack(sw_wdata);
   assign unused_sw_bits = ^{sw_wdata[63:56], sw_wdata[25:23], sw_wdata[19], sw_wdata[16:6]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (sw_wr) begin
         q <= sw_val;
      end else begin
         if (wrap_ev)   q.wrap <= 1'b1;
         if (trig)      q.trg  <= 1'b1;
         if (ext_abort) q.ea   <= 1'b1;
         if (!q.stopped && cause_vld) begin
            q.stopped <= 1'b1;
            q.irq     <= 1'b1;
            q.ec      <= cause_ec;
            q.code    <= cause_code;
         end
      end
   end

   p_first_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (q.stopped && !sw_wr) |=> (q.stopped && $stable(q.code) && $stable(q.ec)));
   p_wrap_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (q.wrap && !sw_wr) |=> q.wrap);
   p_trg_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && !sw_wr) |=> q.trg);
   p_irq_on_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!q.stopped && cause_vld && !sw_wr) |=> (q.irq && q.stopped));
endmodule

// File: rtl/trace_sink_ctrl.sv
module trace_sink_ctrl
   import tsb_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_vld,
   input  logic [7:0]        byte_data,
   input  logic [ADDR_W-1:0] base_ptr,
   input  logic [ADDR_W-1:0] limit_ptr,
   input  logic              circ_mode,
   input  logic              trig_pulse,
   input  logic              mstop_pulse,
   input  logic              flt_vld,
   input  logic              flt_stage2,
   input  logic [5:0]        flt_code,
   input  logic              ext_abort,
   input  logic              sw_wr,
   input  logic [63:0]       sw_wdata,
   output logic [63:0]       sw_rdata,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              irq
);
   synd_t             st;
   logic              take;
   logic              at_end;
   logic              wrap_ev;
   logic [ADDR_W-1:0] wptr;
   logic              cause_vld;
   logic [CODE_W-1:0] cause_ec;
   logic [CODE_W-1:0] cause_code;

   assign take      = byte_vld && !st.stopped;
   assign wrap_ev   = take && at_end;
   assign mem_we    = take;
   assign mem_addr  = wptr;
   assign mem_wdata = byte_data;
   assign irq       = st.irq;
   assign sw_rdata  = synd_pack(st);

   tsb_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_ptr  (base_ptr),
      .limit_ptr (limit_ptr),
      .take      (take),
      .wptr      (wptr),
      .at_end    (at_end)
   );

   tsb_cause u_cause (
      .flt_vld    (flt_vld),
      .flt_stage2 (flt_stage2),
      .flt_code   (flt_code),
      .ext_abort  (ext_abort),
      .mstop      (mstop_pulse),
      .trig       (trig_pulse),
      .fill_wrap  (wrap_ev && !circ_mode),
      .cause_vld  (cause_vld),
      .cause_ec   (cause_ec),
      .cause_code (cause_code)
   );

   tsb_synd u_synd (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_wr      (sw_wr),
      .sw_wdata   (sw_wdata),
      .wrap_ev    (wrap_ev),
      .trig       (trig_pulse),
      .ext_abort  (ext_abort),
      .cause_vld  (cause_vld),
      .cause_ec   (cause_ec),
      .cause_code (cause_code),
      .q          (st)
   );

   p_fill_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && at_end && !circ_mode && !sw_wr) |=> (sw_rdata[17] && !mem_we));
   p_circ_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && at_end && circ_mode && !sw_wr && !trig_pulse && !mstop_pulse
       && !flt_vld && !ext_abort) |=> (!sw_rdata[17] && sw_rdata[20]));
   p_ea_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_abort && !sw_wr) |=> (sw_rdata[18] && sw_rdata[17]));
endmodule

// File: tb/trace_sink_ctrl_test.sv
module trace_sink_ctrl_test;
   localparam int PERIOD = 10;
   localparam int AW     = 32;
   localparam logic [AW-1:0] BASE  = 32'h0000_0100;
   localparam logic [AW-1:0] LIMIT = 32'h0000_0108;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          byte_vld = 0, circ_mode = 0, trig_pulse = 0, mstop_pulse = 0;
   logic          flt_vld = 0, flt_stage2 = 0, ext_abort = 0, sw_wr = 0;
   logic [7:0]    byte_data = 0;
   logic [5:0]    flt_code = 0;
   logic [63:0]   sw_wdata = 0;
   logic [AW-1:0] base_ptr = BASE, limit_ptr = LIMIT;
   logic [63:0]   sw_rdata;
   logic          mem_we, irq;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;

   int n_chk = 0, n_bad = 0;

   // reference model state
   logic [AW-1:0] m_ptr;
   logic [23:0]   m_mss2;
   logic [5:0]    m_ec, m_code;
   logic          m_irq, m_trg, m_wrap, m_ea, m_s;

   always #(PERIOD/2) clk = ~clk;

   trace_sink_ctrl #(.ADDR_W(AW)) uut (.*);

   function automatic logic [63:0] m_word();
      logic [63:0] w = '0;
      w[55:32] = m_mss2; w[31:26] = m_ec; w[22] = m_irq; w[21] = m_trg;
      w[20] = m_wrap; w[18] = m_ea; w[17] = m_s; w[5:0] = m_code;
      return w;
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic m_reset();
      m_ptr = base_ptr; m_mss2 = 0; m_ec = 0; m_code = 0;
      {m_irq, m_trg, m_wrap, m_ea, m_s} = '0;
   endtask

   task automatic m_step();
      logic acc, last, wev;
      acc  = byte_vld && !m_s;
      last = (m_ptr == limit_ptr - 1);
      wev  = acc && last;
      if (sw_wr) begin
         m_mss2 = sw_wdata[55:32]; m_ec = sw_wdata[31:26]; m_irq = sw_wdata[22];
         m_trg = sw_wdata[21]; m_wrap = sw_wdata[20]; m_ea = sw_wdata[18];
         m_s = sw_wdata[17]; m_code = sw_wdata[5:0];
      end else begin
         logic hit = 1'b1;
         logic [5:0] ec = 6'd0, cd = 6'd0;
         if (flt_vld)                  begin ec = flt_stage2 ? 6'b100101 : 6'b100100; cd = flt_code; end
         else if (ext_abort)           cd = 6'd0;
         else if (mstop_pulse)         cd = 6'd3;
         else if (trig_pulse)          cd = 6'd2;
         else if (wev && !circ_mode)   cd = 6'd1;
         else                          hit = 1'b0;
         if (wev) m_wrap = 1;
         if (trig_pulse) m_trg = 1;
         if (ext_abort) m_ea = 1;
         if (!m_s && hit) begin m_s = 1; m_irq = 1; m_ec = ec; m_code = cd; end
      end
      if (acc) m_ptr = last ? base_ptr : m_ptr + 1;
   endtask

   // inputs are set just after a falling edge; compare combinational outputs,
   // advance the model at the rising edge, compare the status at the next fall
   task automatic cycle(string tag);
      #1;
      chk({tag, " strobe"}, 64'(mem_we), 64'(byte_vld && !m_s));
      if (byte_vld && !m_s) begin
         chk({tag, " addr"}, 64'(mem_addr), 64'(m_ptr));
         chk({tag, " data"}, 64'(mem_wdata), 64'(byte_data));
      end
      m_step();
      @(negedge clk);
      chk({tag, " status"}, sw_rdata, m_word());
      chk({tag, " irq R9"}, 64'(irq), 64'(m_irq));
      {byte_vld, trig_pulse, mstop_pulse, flt_vld, ext_abort, sw_wr} = '0;
   endtask

   task automatic sw_write(logic [63:0] v);
      sw_wr = 1; sw_wdata = v; cycle("R12 swwrite");
   endtask

   task automatic bytes(int n, string tag);
      for (int i = 0; i < n; i++) begin
         byte_vld = 1; byte_data = 8'(i * 7 + 3); cycle(tag);
      end
   endtask

   initial begin
      #(PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1; m_reset();
      @(negedge clk);
      // R1 reset state
      chk("R1 status", sw_rdata, 64'h0);
      chk("R1 irq", 64'(irq), 64'h0);
      byte_vld = 1; #1;
      chk("R1 first addr", 64'(mem_addr), 64'(BASE));
      cycle("R1");
      // R2 sequential writes
      bytes(3, "R2");
      // R3/R4 fill mode wrap, R10 no writes after
      bytes(4, "R3");
      chk("R4 fill stop word", sw_rdata, 64'h0000_0000_0052_0001);
      byte_vld = 1; #1;
      chk("R10 no write when stopped", 64'(mem_we), 64'h0);
      cycle("R10");
      // R12 all ones then zero
      sw_write('1);
      chk("R12 writable mask", sw_rdata, 64'h00FF_FFFF_FC76_003F);
      sw_write('0);
      chk("R12 cleared", sw_rdata, 64'h0);
      // R5 circular mode
      circ_mode = 1;
      bytes(12, "R5");
      chk("R5 wrap only", sw_rdata & 64'h0000_0000_0072_003F, 64'h0000_0000_0010_0000);
      sw_write('0);
      // R6 trigger with same-cycle byte (R11)
      byte_vld = 1; trig_pulse = 1; cycle("R11 byte with stop");
      chk("R6 trigger word", sw_rdata, 64'h0000_0000_0062_0002);
      mstop_pulse = 1; trig_pulse = 1; cycle("R10 later cause");
      chk("R10 first kept", sw_rdata, 64'h0000_0000_0062_0002);
      sw_write('0);
      mstop_pulse = 1; cycle("R6 manual");
      chk("R6 manual word", sw_rdata, 64'h0000_0000_0042_0003);
      sw_write('0);
      // R7 faults
      flt_vld = 1; flt_code = 6'h0D; flt_stage2 = 0; cycle("R7 s1");
      chk("R7 stage1 word", sw_rdata, 64'h0000_0000_9042_000D);
      sw_write('0);
      flt_vld = 1; flt_stage2 = 1; mstop_pulse = 1; cycle("R11 priority");
      chk("R7 stage2 word", sw_rdata, 64'h0000_0000_9442_000D);
      sw_write('0);
      // R8 external abort
      ext_abort = 1; trig_pulse = 1; cycle("R8");
      chk("R8 abort word", sw_rdata, 64'h0000_0000_0066_0000);
      // R12 software beats hardware
      sw_wr = 1; sw_wdata = '0; trig_pulse = 1; cycle("R12 precedence");
      chk("R12 precedence word", sw_rdata, 64'h0);
      // constrained random
      void'($urandom(32'h5eed_1234));
      for (int k = 0; k < 4000; k++) begin
         if (k % 500 == 0) circ_mode = $urandom_range(0, 1);
         byte_vld    = ($urandom_range(0, 99) < 70);
         byte_data   = 8'($urandom);
         trig_pulse  = ($urandom_range(0, 99) < 2);
         mstop_pulse = ($urandom_range(0, 99) < 2);
         flt_vld     = ($urandom_range(0, 99) < 2);
         flt_stage2  = $urandom_range(0, 1);
         flt_code    = 6'($urandom);
         ext_abort   = ($urandom_range(0, 199) < 1);
         sw_wr       = ($urandom_range(0, 99) < 6);
         sw_wdata    = ($urandom_range(0, 1) != 0) ? 64'h0 : {$urandom, $urandom};
         cycle("R2 random");
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule